// File: doc/BRIEF.md
# Programmable CRC and LFSR Generator

A 32-bit Galois-field register, with a polynomial that software writes, serves as a CRC accumulator and as a pseudo-random generator. In CRC mode a valid-qualified data port delivers one to four bytes per clock, and the whole word is folded into the state in that clock. Bytes can be taken with either bit order, and the byte order of a full word can be swapped. In PRNG mode the same register free-runs. It emits one byte per clock, or one bit per clock when an external entropy bit is mixed into the feedback. With the PRNG off and entropy on, the raw entropy bit is passed to the output so that the source can be characterised.

Internally the state and polynomial are always kept in the right-shifting, LSB-first form. When MSB-first order is selected, software sees and writes both registers bit-reversed. It can therefore work with the conventional left-shifting form of the polynomial.

Top module: `crc_lfsr_engine`

## Requirements
- R1: After reset poly_o reads 0xEDB88320, state_o reads 0xFFFFFFFF, rnd_valid_o is 0, and the bit order is LSB first.
- R2: With LSB-first order, a din_valid_i beat processes din_cnt_i+1 bytes, starting at din_i[7:0] and moving upward. Each bit b is taken from bit 0 upward and applies fb = s[0]^b, s = (s>>1) ^ (fb ? poly : 0). The result is visible on state_o in the next cycle.
- R3: With MSB-first order (control bit set), each byte is taken from bit 7 down. poly_o and state_o read, and their write ports load, bit-reversed. A beat therefore applies fb = v[31]^b, v = (v<<1) ^ (fb ? P : 0) to the values that software sees.
- R4: A control write that requests both CRC and PRNG leaves CRC disabled. While CRC is disabled, din_valid_i has no effect on the state.
- R5: When byte swapping is on and din_cnt_i is 3 (four bytes), the word is byte-reversed before it is processed. A partial word is processed unswapped.
- R6: With the PRNG on and entropy off, every clock applies eight steps with b = 0. The next cycle shows rnd_valid_o = 1, and rnd_o is the low byte of the new LSB-first state.
- R7: With the PRNG on and entropy on, every clock applies one step with b = ent_i. The next cycle shows rnd_valid_o = 1 and rnd_o = {7'b0, fb}, where fb = s[0]^ent_i.
- R8: With the PRNG off and entropy on, every clock presents {7'b0, ent_i} on rnd_o with rnd_valid_o = 1 in the next cycle. The state is left unchanged.
- R9: A state write loads the seed in the next cycle. It overrides any CRC or PRNG update in that cycle.
- R10: rnd_valid_o is 0 in the cycle after one in which neither the PRNG nor entropy was enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Write the control fields below |
| ctrl_crc_en_i | input | 1 | Request CRC mode |
| ctrl_prng_en_i | input | 1 | Enable PRNG |
| ctrl_ent_en_i | input | 1 | Enable entropy mixing or raw output |
| ctrl_msb_first_i | input | 1 | 1 selects MSB-first bit order |
| ctrl_bswap_i | input | 1 | Swap the bytes of full input words |
| poly_we_i | input | 1 | Polynomial write strobe |
| poly_wdata_i | input | 32 | Polynomial write data |
| poly_o | output | 32 | Polynomial readback |
| state_we_i | input | 1 | State (seed) write strobe |
| state_wdata_i | input | 32 | State write data |
| state_o | output | 32 | State readback |
| din_valid_i | input | 1 | Input beat valid |
| din_i | input | 32 | Input data |
| din_cnt_i | input | 2 | Byte count minus one |
| ent_i | input | 1 | Entropy bit |
| rnd_valid_o | output | 1 | Random output valid |
| rnd_o | output | 8 | Random byte, or a bit in bit 0 |

## Verification
A wrong bit in the state, or a misrouted feed bit, shows up on state_o one cycle after the beat that caused it. Because every later step feeds that bit back through the polynomial, the error then spreads across the whole register within a few more beats. In PRNG mode the same fault appears on rnd_o in the very next cycle. The sweeps therefore compare state_o after every single beat, across all byte counts and both bit and byte orders. They can then point to the first beat that diverges.

// File: rtl/crc_lfsr_pkg.sv
`timescale 1ns/1ps
package crc_lfsr_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic crc_en;
    logic prng_en;
    logic ent_en;
    logic msb_first;
    logic bswap;
  } gf_cfg_t;
endpackage

// File: rtl/crc_lfsr_cfg.sv
`timescale 1ns/1ps
module crc_lfsr_cfg
  import crc_lfsr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    we_i,
  input  logic    crc_en_i,
  input  logic    prng_en_i,
  input  logic    ent_en_i,
  input  logic    msb_first_i,
  input  logic    bswap_i,
  output gf_cfg_t cfg_o
);
  gf_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      // PRNG wins: CRC is refused whenever PRNG is requested
      cfg_q.crc_en    <= crc_en_i & ~prng_en_i;
      cfg_q.prng_en   <= prng_en_i;
      cfg_q.ent_en    <= ent_en_i;
      cfg_q.msb_first <= msb_first_i;
      cfg_q.bswap     <= bswap_i;
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/crc_lfsr_feed.sv
`timescale 1ns/1ps
module crc_lfsr_feed
  import crc_lfsr_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned NB = W / BYTE_W,
  localparam int unsigned CNT_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [W-1:0]     data_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             msb_first_i,
  input  logic             bswap_i,
  output logic [W-1:0]     feed_o
);
  logic full_word;
  assign full_word = (cnt_i == CNT_W'(NB - 1));

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic [BYTE_W-1:0] sel;
    always_comb begin
      sel = (bswap_i && full_word) ? data_i[(NB-1-k)*BYTE_W +: BYTE_W]
                                   : data_i[k*BYTE_W +: BYTE_W];
    end
    for (genvar j = 0; j < BYTE_W; j++) begin : g_bit
      assign feed_o[k*BYTE_W + j] = msb_first_i ? sel[BYTE_W-1-j] : sel[j];
    end
  end
endmodule

// File: rtl/crc_lfsr_core.sv
`timescale 1ns/1ps
module crc_lfsr_core
  import crc_lfsr_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned NB = W / BYTE_W,
  localparam int unsigned CNT_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [W-1:0]     state_i,
  input  logic [W-1:0]     poly_i,
  input  logic [W-1:0]     feed_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ent_i,
  output logic [W-1:0]     crc_res_o,
  output logic [W-1:0]     prng_res_o,
  output logic [W-1:0]     ent_res_o,
  output logic             ent_fb_o
);
  function automatic logic [W-1:0] gf_step(input logic [W-1:0] s,
                                           input logic [W-1:0] p,
                                           input logic         b);
    logic fb;
    fb = s[0] ^ b;
    return (s >> 1) ^ (fb ? p : '0);
  endfunction

  // unrolled CRC chain, one stage per input bit
  logic [W-1:0] chain [0:W];
  assign chain[0] = state_i;
  for (genvar k = 0; k < W; k++) begin : g_crc
    assign chain[k+1] = gf_step(chain[k], poly_i, feed_i[k]);
  end

  always_comb begin
    crc_res_o = chain[W];
    for (int n = 0; n < NB; n++) begin
      if (cnt_i == CNT_W'(n)) crc_res_o = chain[(n+1)*BYTE_W];
    end
  end

  // free-running PRNG chain, one byte per clock
  logic [W-1:0] pchain [0:BYTE_W];
  assign pchain[0] = state_i;
  for (genvar k = 0; k < BYTE_W; k++) begin : g_prng
    assign pchain[k+1] = gf_step(pchain[k], poly_i, 1'b0);
  end
  assign prng_res_o = pchain[BYTE_W];

  assign ent_fb_o  = state_i[0] ^ ent_i;
  assign ent_res_o = gf_step(state_i, poly_i, ent_i);
endmodule

// File: rtl/crc_lfsr_engine.sv
`timescale 1ns/1ps
module crc_lfsr_engine
  import crc_lfsr_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] POLY_RST  = 'hEDB88320,
  parameter logic [W-1:0] STATE_RST = '1,
  localparam int unsigned NB = W / BYTE_W,
  localparam int unsigned CNT_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              ctrl_crc_en_i,
  input  logic              ctrl_prng_en_i,
  input  logic              ctrl_ent_en_i,
  input  logic              ctrl_msb_first_i,
  input  logic              ctrl_bswap_i,
  input  logic              poly_we_i,
  input  logic [W-1:0]      poly_wdata_i,
  output logic [W-1:0]      poly_o,
  input  logic              state_we_i,
  input  logic [W-1:0]      state_wdata_i,
  output logic [W-1:0]      state_o,
  input  logic              din_valid_i,
  input  logic [W-1:0]      din_i,
  input  logic [CNT_W-1:0]  din_cnt_i,
  input  logic              ent_i,
  output logic              rnd_valid_o,
  output logic [BYTE_W-1:0] rnd_o
);
  function automatic logic [W-1:0] rev(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  gf_cfg_t cfg;
  logic crc_en_w, prng_en_w, ent_en_w;

  crc_lfsr_cfg u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (ctrl_we_i),
    .crc_en_i    (ctrl_crc_en_i),
    .prng_en_i   (ctrl_prng_en_i),
    .ent_en_i    (ctrl_ent_en_i),
    .msb_first_i (ctrl_msb_first_i),
    .bswap_i     (ctrl_bswap_i),
    .cfg_o       (cfg)
  );

  assign crc_en_w  = cfg.crc_en;
  assign prng_en_w = cfg.prng_en;
  assign ent_en_w  = cfg.ent_en;

  logic [W-1:0] poly_q, state_q, state_d;
  logic [W-1:0] feed, crc_res, prng_res, ent_res;
  logic         ent_fb;
  logic         rnd_valid_q, rnd_valid_d;
  logic [BYTE_W-1:0] rnd_q, rnd_d;

  crc_lfsr_feed #(.W(W)) u_feed (
    .data_i      (din_i),
    .cnt_i       (din_cnt_i),
    .msb_first_i (cfg.msb_first),
    .bswap_i     (cfg.bswap),
    .feed_o      (feed)
  );

  crc_lfsr_core #(.W(W)) u_core (
    .state_i    (state_q),
    .poly_i     (poly_q),
    .feed_i     (feed),
    .cnt_i      (din_cnt_i),
    .ent_i      (ent_i),
    .crc_res_o  (crc_res),
    .prng_res_o (prng_res),
    .ent_res_o  (ent_res),
    .ent_fb_o   (ent_fb)
  );

  // state held in LSB-first form; MSB-first view is the bit reverse
  assign poly_o  = cfg.msb_first ? rev(poly_q)  : poly_q;
  assign state_o = cfg.msb_first ? rev(state_q) : state_q;

  always_comb begin
    state_d = state_q;
    if (state_we_i) begin
      state_d = cfg.msb_first ? rev(state_wdata_i) : state_wdata_i;
    end else if (cfg.prng_en) begin
      state_d = cfg.ent_en ? ent_res : prng_res;
    end else if (cfg.crc_en && din_valid_i) begin
      state_d = crc_res;
    end
  end

  always_comb begin
    rnd_valid_d = cfg.prng_en | cfg.ent_en;
    rnd_d       = '0;
    if (cfg.prng_en) begin
      if (cfg.ent_en) rnd_d[0] = ent_fb;
      else            rnd_d    = prng_res[BYTE_W-1:0];
    end else if (cfg.ent_en) begin
      rnd_d[0] = ent_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poly_q      <= POLY_RST;
      state_q     <= STATE_RST;
      rnd_valid_q <= 1'b0;
      rnd_q       <= '0;
    end else begin
      if (poly_we_i) poly_q <= cfg.msb_first ? rev(poly_wdata_i) : poly_wdata_i;
      state_q     <= state_d;
      rnd_valid_q <= rnd_valid_d;
      rnd_q       <= rnd_d;
    end
  end

  assign rnd_valid_o = rnd_valid_q;
  assign rnd_o       = rnd_q;
endmodule

// File: rtl/crc_lfsr_checker.sv
`timescale 1ns/1ps
module crc_lfsr_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ctrl_we_i,
  input logic         state_we_i,
  input logic [W-1:0] state_wdata_i,
  input logic [W-1:0] state_o,
  input logic         crc_en,
  input logic         prng_en,
  input logic         ent_en,
  input logic         rnd_valid_o,
  input logic [7:0]   rnd_o
);
  assert_mode_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(crc_en && prng_en));

  assert_crc_off_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!crc_en && !prng_en && !state_we_i && !ctrl_we_i) |=> $stable(state_o));

  assert_seed_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_we_i && !ctrl_we_i) |=> (state_o == $past(state_wdata_i)));

  assert_bit_rate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_en && !ctrl_we_i) |=> (rnd_valid_o && rnd_o[7:1] == 7'd0));

  assert_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prng_en && !ent_en) |=> !rnd_valid_o);
endmodule

bind crc_lfsr_engine crc_lfsr_checker #(.W(W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ctrl_we_i     (ctrl_we_i),
  .state_we_i    (state_we_i),
  .state_wdata_i (state_wdata_i),
  .state_o       (state_o),
  .crc_en        (crc_en_w),
  .prng_en       (prng_en_w),
  .ent_en        (ent_en_w),
  .rnd_valid_o   (rnd_valid_o),
  .rnd_o         (rnd_o)
);

// File: tb/tb_crc_lfsr_engine.sv
`timescale 1ns/1ps
module tb_crc_lfsr_engine;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ctrl_we = 0, c_crc = 0, c_prng = 0, c_ent = 0, c_msb = 0, c_bsw = 0;
  logic poly_we = 0, state_we = 0, din_valid = 0, ent = 0;
  logic [31:0] poly_wd = 0, state_wd = 0, din = 0;
  logic [1:0]  din_cnt = 0;
  logic [31:0] poly_o, state_o;
  logic        rnd_valid;
  logic [7:0]  rnd;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  crc_lfsr_engine dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ctrl_we_i(ctrl_we), .ctrl_crc_en_i(c_crc), .ctrl_prng_en_i(c_prng),
    .ctrl_ent_en_i(c_ent), .ctrl_msb_first_i(c_msb), .ctrl_bswap_i(c_bsw),
    .poly_we_i(poly_we), .poly_wdata_i(poly_wd), .poly_o(poly_o),
    .state_we_i(state_we), .state_wdata_i(state_wd), .state_o(state_o),
    .din_valid_i(din_valid), .din_i(din), .din_cnt_i(din_cnt), .ent_i(ent),
    .rnd_valid_o(rnd_valid), .rnd_o(rnd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bswap32(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  // reflected model on the LSB-first view
  function automatic logic [31:0] m_lsb(input logic [31:0] s, input logic [31:0] p,
                                        input logic [31:0] d, input int nb, input logic sw);
    logic [31:0] w;
    logic fb;
    w = (sw && nb == 4) ? bswap32(d) : d;
    for (int k = 0; k < nb; k++)
      for (int j = 0; j < 8; j++) begin
        fb = s[0] ^ w[8*k+j];
        s = (s >> 1) ^ (fb ? p : 32'h0);
      end
    return s;
  endfunction

  // left-shifting model on the MSB-first view
  function automatic logic [31:0] m_msb(input logic [31:0] v, input logic [31:0] p,
                                        input logic [31:0] d, input int nb, input logic sw);
    logic [31:0] w;
    logic fb;
    w = (sw && nb == 4) ? bswap32(d) : d;
    for (int k = 0; k < nb; k++)
      for (int j = 0; j < 8; j++) begin
        fb = v[31] ^ w[8*k+7-j];
        v = (v << 1) ^ (fb ? p : 32'h0);
      end
    return v;
  endfunction

  task automatic ctrl_write(input logic cr, input logic pr, input logic en,
                            input logic ms, input logic bs);
    @(negedge clk);
    ctrl_we = 1; c_crc = cr; c_prng = pr; c_ent = en; c_msb = ms; c_bsw = bs;
    @(negedge clk);
    ctrl_we = 0;
  endtask

  task automatic poly_write(input logic [31:0] v);
    @(negedge clk); poly_we = 1; poly_wd = v;
    @(negedge clk); poly_we = 0;
  endtask

  task automatic state_write(input logic [31:0] v);
    @(negedge clk); state_we = 1; state_wd = v;
    @(negedge clk); state_we = 0;
  endtask

  task automatic beat(input logic [31:0] d, input logic [1:0] c);
    @(negedge clk); din_valid = 1; din = d; din_cnt = c;
    @(negedge clk); din_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] s, p, d, x, st;
    logic fb;
    x = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R1 poly reset", poly_o, 32'hEDB88320);
    check("R1 state reset", state_o, 32'hFFFFFFFF);
    check("R1 rnd_valid reset", {31'd0, rnd_valid}, 32'd0);
    rst_ni = 1;
    @(negedge clk);

    // R2 known vector "123456789", LSB first, no final inversion
    ctrl_write(1, 0, 0, 0, 0);
    beat(32'h34333231, 2'd3);
    beat(32'h38373635, 2'd3);
    beat(32'h00000039, 2'd0);
    check("R2 crc32 check value", state_o, 32'h340BC6D9);

    // R3 same vector MSB first with the normal-form polynomial
    ctrl_write(1, 0, 0, 1, 0);
    poly_write(32'h04C11DB7);
    state_write(32'hFFFFFFFF);
    check("R3 poly view msb", poly_o, 32'h04C11DB7);
    beat(32'h34333231, 2'd3);
    beat(32'h38373635, 2'd3);
    beat(32'h00000039, 2'd0);
    check("R3 crc32 msb check value", state_o, 32'h0376E6E7);
    ctrl_write(1, 0, 0, 0, 0);
    check("R3 poly view lsb", poly_o, 32'hEDB88320);

    // R2 R3 R5 sweep: bit order x swap x byte count
    for (int ms = 0; ms < 2; ms++)
      for (int bs = 0; bs < 2; bs++) begin
        ctrl_write(1, 0, 0, ms[0], bs[0]);
        p = ms ? 32'h1EDC6F41 : 32'h82F63B78;
        poly_write(p);
        s = 32'hA5A5_0000 + 32'(ms * 2 + bs);
        state_write(s);
        for (int i = 0; i < 48; i++) begin
          x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
          d = x;
          beat(d, 2'(i % 4));
          s = ms ? m_msb(s, p, d, (i % 4) + 1, bs[0]) : m_lsb(s, p, d, (i % 4) + 1, bs[0]);
          if (bs && (i % 4) == 3) check("R5 full word swap", state_o, s);
          else if (ms) check("R3 msb beat", state_o, s);
          else check("R2 lsb beat", state_o, s);
        end
      end

    // R4 CRC disabled: din ignored
    ctrl_write(0, 0, 0, 0, 0);
    poly_write(32'hEDB88320);
    state_write(32'hCAFE_F00D);
    beat(32'hDEAD_BEEF, 2'd3);
    beat(32'h0000_0011, 2'd0);
    check("R4 din ignored when crc off", state_o, 32'hCAFE_F00D);
    check("R10 no rnd when idle", {31'd0, rnd_valid}, 32'd0);

    // R4 R6: request both; PRNG wins, din ignored
    s = 32'h0000_0001;
    state_write(s);
    ctrl_write(1, 1, 0, 0, 0);
    din_valid = 1; din = 32'hFFFF_FFFF; din_cnt = 2'd3;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); @(negedge clk);
      s = m_lsb(s, 32'hEDB88320, 32'h0, 1, 1'b0);
      check("R6 prng state", state_o, s);
      check("R6 prng byte", {23'd0, rnd_valid, rnd}, {23'd0, 1'b1, s[7:0]});
    end
    check("R4 crc refused under prng", state_o, s);
    din_valid = 0;

    // R9 seed write overrides PRNG step
    state_we = 1; state_wd = 32'h0BAD_CAFE;
    @(posedge clk); @(negedge clk);
    state_we = 0;
    check("R9 seed override", state_o, 32'h0BAD_CAFE);
    s = 32'h0BAD_CAFE;
    @(posedge clk); @(negedge clk);
    s = m_lsb(s, 32'hEDB88320, 32'h0, 1, 1'b0);
    check("R9 prng resumes from seed", state_o, s);

    // R7 entropy mixing, one bit per clock
    ctrl_write(0, 1, 1, 0, 0);
    s = state_o;
    for (int i = 0; i < 40; i++) begin
      ent = ((i * 7) % 5) < 2;
      @(posedge clk); @(negedge clk);
      fb = s[0] ^ ent;
      s = (s >> 1) ^ (fb ? 32'hEDB88320 : 32'h0);
      check("R7 entropy state", state_o, s);
      check("R7 entropy bit", {23'd0, rnd_valid, rnd}, {23'd0, 1'b1, 7'd0, fb});
    end

    // R8 raw entropy, state frozen
    ctrl_write(0, 0, 1, 0, 0);
    st = state_o;
    for (int i = 0; i < 16; i++) begin
      ent = i[0] ^ i[2];
      @(posedge clk); @(negedge clk);
      check("R8 raw bit", {23'd0, rnd_valid, rnd}, {23'd0, 1'b1, 7'd0, ent});
      check("R8 state frozen", state_o, st);
    end

    // R10 quiet after disabling
    ctrl_write(0, 0, 0, 0, 0);
    @(posedge clk); @(negedge clk);
    check("R10 rnd_valid low", {31'd0, rnd_valid}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule